// File: doc/BRIEF.md
# Z80 Instruction Boundary Sequencer

This block sits after a bus-cycle classifier and takes one event per completed bus cycle, each event being a cycle kind and the byte seen on the data bus. It follows the byte structure of Z80 instructions: prefix bytes, a two-byte prefix with a displacement placed ahead of the opcode, a displacement after the opcode, zero to two immediate bytes, and read and write operands taken from the data cycles that the instruction performs. When an instruction ends, it raises a one-cycle completion pulse. The pulse carries the assembled prefix, opcode, displacement, immediate, read value, write value and byte count.

The operand counts for each opcode come from an outside combinational table. The block drives the current prefix and the candidate opcode byte onto the lookup outputs, and it reads the answer back in the same cycle. Protocol faults raise a one-cycle error pulse with a 3-bit code, and the sequencer then returns to its idle state.

Top module: `z80_insn_seq`

## Requirements
- R1: Event kinds on `evType` are 0 none, 1 opcode fetch, 2 memory read, 3 memory write, 4 I/O read, 5 I/O write and 6 interrupt acknowledge. In idle, only a kind-1 event starts an instruction, and every other event is ignored.
- R2: A fetched byte of CB, ED, DD or FD is taken as a prefix. A later DD, ED or FD fetch replaces it, so only the last one is kept. Any other fetched byte is the opcode. In that same cycle, `lkPrefix` (zero when there is no prefix) and `lkOpcode` present the lookup key.
- R3: After a DD or FD prefix, a CB fetch forms the 16-bit prefix {first byte, CB}. The next memory read is the displacement, sign-extended to 16 bits, and the memory read after it is the opcode.
- R4: A displacement that follows the opcode, and any immediate bytes, are taken from the next completed events of any kind. The displacement is sign-extended, and a two-byte immediate takes its low byte first.
- R5: Read operands come only from memory or I/O read events, and write operands only from memory or I/O write events. Two-byte operands take the low byte first. The exception is a two-byte write whose lookup big-endian flag is set: there the first byte is the high byte.
- R6: For an instruction whose lookup repeat flag is set, a read event that arrives after its operands are complete starts a new operand capture. The instruction is published at the first event that is not a read.
- R7: `insDone` pulses in the cycle after the edge that captured the last byte the instruction needs. If an event of the wrong kind arrives while operands are still due, the instruction is published without that event's byte. That event is then handled as in idle. If it is a fetch that completes an instruction by itself, that instruction is published one cycle later.
- R8: `insLen` counts every event that the instruction consumed, including its first fetch.
- R9: `errCode` is 1 for a non-fetch event after a prefix, 2 for a non-memory-read event where the pre-opcode displacement is due, and 3 for a non-memory-read event where the opcode after that displacement is due. Each is reported with an `errValid` pulse. The sequencer restarts, and the offending event is handled as in idle.
- R10: An opcode whose lookup returns not-valid gives `errCode` 4 with an `errValid` pulse. The event is consumed and nothing is published.
- R11: While `rstN` is low, `insDone` and `errValid` are 0, all published fields are 0, and any partly assembled instruction is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evValid | input | 1 | A completed bus-cycle event is present |
| evType | input | 3 | Event kind (encoding in R1) |
| evData | input | 8 | Data byte of the event |
| lkPrefix | output | 16 | Lookup key: current prefix |
| lkOpcode | output | 8 | Lookup key: candidate opcode byte |
| lkValid | input | 1 | Opcode exists for this prefix |
| lkDisp | input | 1 | One displacement byte follows the opcode |
| lkImm | input | 2 | Immediate byte count, 0 to 2 |
| lkRead | input | 2 | Read operand byte count, 0 to 2 |
| lkWrite | input | 2 | Write operand byte count, 0 to 2 |
| lkWrBigEnd | input | 1 | Two-byte write takes its high byte first |
| lkRepeat | input | 1 | Block instruction that repeats its operands |
| insDone | output | 1 | One-cycle instruction-complete pulse |
| insPrefix | output | 16 | Prefix of the completed instruction |
| insOpcode | output | 8 | Opcode byte |
| insDisp | output | 16 | Sign-extended displacement |
| insImm | output | 16 | Immediate value |
| insRead | output | 16 | Read operand value |
| insWrite | output | 16 | Write operand value |
| insLen | output | LEN_W | Events consumed by the instruction |
| errValid | output | 1 | One-cycle protocol error pulse |
| errCode | output | 3 | Error code (R9, R10) |

## Verification
The main sequencing is tried with the following patterns:
- A bare opcode.
- One-byte and two-byte immediates.
- One-byte reads.
- Little-endian and big-endian two-byte writes. These separate the two byte orders, because the same pair of bus bytes yields different words.
- An indexed opcode with displacement and immediate, and the four-byte indexed bit form, whose pre-opcode displacement must not be mistaken for the opcode.
- A chain of prefixes, which shows that only the last prefix survives.

A repeating block transfer, and a read instruction cut short by a fetch, separate publishing at the terminating event from publishing at the last captured byte. The fault patterns show whether the offending event is dropped or restarts decoding.

// File: rtl/z80seq_pkg.sv
package z80seq_pkg;

  typedef enum logic [2:0] {
    EV_NONE  = 3'd0,
    EV_FETCH = 3'd1,
    EV_MRD   = 3'd2,
    EV_MWR   = 3'd3,
    EV_IORD  = 3'd4,
    EV_IOWR  = 3'd5,
    EV_INTA  = 3'd6
  } evKind_e;

  // Per-opcode shape returned by the external lookup
  typedef struct packed {
    logic       dis;
    logic [1:0] imm;
    logic [1:0] rd;
    logic [1:0] wr;
    logic       bigEnd;
    logic       rpt;
  } opCfg_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic startIns;
    logic loadPfx;
    logic extPfx;
    logic capOpc;
    logic capDisp;
    logic capImmLo;
    logic capImmHi;
    logic capRd;
    logic rdHi;
    logic capWr;
    logic wrHi;
    logic incLen;
    logic pubNow;
    logic pubOld;
  } strobe_t;

  localparam logic [2:0] ERR_NOFETCH = 3'd1;
  localparam logic [2:0] ERR_NODISP  = 3'd2;
  localparam logic [2:0] ERR_NOOPC   = 3'd3;
  localparam logic [2:0] ERR_INVALID = 3'd4;

endpackage

// File: rtl/z80seq_datapath.sv
module z80seq_datapath
  import z80seq_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [7:0]       evData,
  output logic [15:0]      curPrefix,
  output logic             insDone,
  output logic [15:0]      insPrefix,
  output logic [7:0]       insOpcode,
  output logic [15:0]      insDisp,
  output logic [15:0]      insImm,
  output logic [15:0]      insRead,
  output logic [15:0]      insWrite,
  output logic [LEN_W-1:0] insLen
);

  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  logic [15:0]      pfxQ, dispQ, immQ, rdQ, wrQ;
  logic [7:0]       opcQ;
  logic [LEN_W-1:0] lenQ;

  logic [15:0]      mPfx, mDisp, mImm, mRd, mWr;
  logic [7:0]       mOpc;
  logic [LEN_W-1:0] mLen;

  // Working record after this cycle's captures
  always_comb begin
    mPfx  = stb.startIns ? '0 : pfxQ;
    mOpc  = stb.startIns ? '0 : opcQ;
    mDisp = stb.startIns ? '0 : dispQ;
    mImm  = stb.startIns ? '0 : immQ;
    mRd   = stb.startIns ? '0 : rdQ;
    mWr   = stb.startIns ? '0 : wrQ;
    if (stb.startIns)                   mLen = LEN_ONE;
    else if (stb.incLen && lenQ != LEN_MAX) mLen = lenQ + LEN_ONE;
    else                                mLen = lenQ;

    if (stb.loadPfx) mPfx = {8'h00, evData};
    if (stb.extPfx)  mPfx = {pfxQ[7:0], evData};
    if (stb.capOpc)  mOpc = evData;
    if (stb.capDisp) mDisp = {{8{evData[7]}}, evData};
    if (stb.capImmLo) mImm[7:0]  = evData;
    if (stb.capImmHi) mImm[15:8] = evData;
    if (stb.capRd) begin
      if (stb.rdHi) mRd[15:8] = evData;
      else          mRd[7:0]  = evData;
    end
    if (stb.capWr) begin
      if (stb.wrHi) mWr[15:8] = evData;
      else          mWr[7:0]  = evData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pfxQ <= '0; opcQ <= '0; dispQ <= '0; immQ <= '0;
      rdQ <= '0; wrQ <= '0; lenQ <= '0;
    end else begin
      pfxQ <= mPfx; opcQ <= mOpc; dispQ <= mDisp; immQ <= mImm;
      rdQ <= mRd; wrQ <= mWr; lenQ <= mLen;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      insDone <= 1'b0;
      insPrefix <= '0; insOpcode <= '0; insDisp <= '0; insImm <= '0;
      insRead <= '0; insWrite <= '0; insLen <= '0;
    end else begin
      insDone <= stb.pubNow | stb.pubOld;
      if (stb.pubNow) begin
        insPrefix <= mPfx; insOpcode <= mOpc; insDisp <= mDisp; insImm <= mImm;
        insRead <= mRd; insWrite <= mWr; insLen <= mLen;
      end else if (stb.pubOld) begin
        insPrefix <= pfxQ; insOpcode <= opcQ; insDisp <= dispQ; insImm <= immQ;
        insRead <= rdQ; insWrite <= wrQ; insLen <= lenQ;
      end
    end
  end

  assign curPrefix = pfxQ;

  // R8: every published instruction consumed at least its first fetch
  a_r8_len_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    insDone |-> insLen != '0);

  // R5: a single event never feeds both operand registers
  a_r5_one_operand: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.capRd, stb.capWr, stb.capImmLo, stb.capImmHi}));

endmodule

// File: rtl/z80seq_control.sv
module z80seq_control
  import z80seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        evValid,
  input  logic [2:0]  evType,
  input  logic [7:0]  evData,
  input  logic        lkValid,
  input  opCfg_t      lkCfg,
  input  logic [15:0] curPrefix,
  output logic [15:0] lkPrefix,
  output logic [7:0]  lkOpcode,
  output strobe_t     stb,
  output logic        errValid,
  output logic [2:0]  errCode
);

  typedef enum logic [3:0] {
    S_IDLE, S_PFX, S_PDSP, S_POPC, S_POSTD,
    S_IMM1, S_IMM2, S_OPER, S_RPT, S_FIN
  } st_e;

  st_e        state, nState, advFrom;
  opCfg_t     cfgQ, nCfg, advCfg;
  logic [1:0] rdGot, wrGot, nRd, nWr;
  logic       errNext;
  logic [2:0] codeNext;
  logic       actIdle, doOpc, adv;
  logic [15:0] opcPfx;
  st_e        advTo;
  strobe_t    s;

  logic isFetch, isRd, isWr, isMrd, pfxByte, idxPfx, chainByte;
  assign isFetch   = evType == EV_FETCH;
  assign isMrd     = evType == EV_MRD;
  assign isRd      = (evType == EV_MRD) || (evType == EV_IORD);
  assign isWr      = (evType == EV_MWR) || (evType == EV_IOWR);
  assign chainByte = (evData == 8'hDD) || (evData == 8'hED) || (evData == 8'hFD);
  assign pfxByte   = chainByte || (evData == 8'hCB);
  assign idxPfx    = (curPrefix[7:0] == 8'hDD) || (curPrefix[7:0] == 8'hFD);

  // Next field stage after the one just taken
  function automatic st_e nextAfter(opCfg_t c, st_e from);
    if (from == S_POPC && c.dis) return S_POSTD;
    if ((from == S_POPC || from == S_POSTD) && c.imm != 2'd0) return S_IMM1;
    if (from == S_IMM1 && c.imm == 2'd2) return S_IMM2;
    if (c.rd != 2'd0 || c.wr != 2'd0) return S_OPER;
    return S_IDLE;
  endfunction

  always_comb begin
    s = '0;
    nState = state; nCfg = cfgQ; nRd = rdGot; nWr = wrGot;
    errNext = 1'b0; codeNext = 3'd0;
    actIdle = 1'b0; doOpc = 1'b0; adv = 1'b0; advFrom = S_POPC;
    opcPfx = curPrefix;

    unique case (state)
      S_IDLE: actIdle = evValid;
      S_PFX: if (evValid) begin
        if (!isFetch) begin
          errNext = 1'b1; codeNext = ERR_NOFETCH; nState = S_IDLE;
        end else if (idxPfx && evData == 8'hCB) begin
          s.extPfx = 1'b1; s.incLen = 1'b1; nState = S_PDSP;
        end else if (chainByte) begin
          s.loadPfx = 1'b1; s.incLen = 1'b1;
        end else begin
          doOpc = 1'b1; s.incLen = 1'b1;
        end
      end
      S_PDSP: if (evValid) begin
        if (isMrd) begin
          s.capDisp = 1'b1; s.incLen = 1'b1; nState = S_POPC;
        end else begin
          errNext = 1'b1; codeNext = ERR_NODISP; nState = S_IDLE; actIdle = 1'b1;
        end
      end
      S_POPC: if (evValid) begin
        if (isMrd) begin
          doOpc = 1'b1; s.incLen = 1'b1;
        end else begin
          errNext = 1'b1; codeNext = ERR_NOOPC; nState = S_IDLE; actIdle = 1'b1;
        end
      end
      S_POSTD: if (evValid) begin
        s.capDisp = 1'b1; s.incLen = 1'b1; adv = 1'b1; advFrom = S_POSTD;
      end
      S_IMM1: if (evValid) begin
        s.capImmLo = 1'b1; s.incLen = 1'b1; adv = 1'b1; advFrom = S_IMM1;
      end
      S_IMM2: if (evValid) begin
        s.capImmHi = 1'b1; s.incLen = 1'b1; adv = 1'b1; advFrom = S_IMM2;
      end
      S_OPER: if (evValid) begin
        if (isRd && rdGot < cfgQ.rd) begin
          s.capRd = 1'b1; s.rdHi = rdGot == 2'd1; s.incLen = 1'b1;
          nRd = rdGot + 2'd1;
          if (nRd == cfgQ.rd && wrGot == cfgQ.wr) begin
            if (cfgQ.rpt) nState = S_RPT;
            else begin s.pubNow = 1'b1; nState = S_IDLE; end
          end
        end else if (isWr && wrGot < cfgQ.wr) begin
          s.capWr = 1'b1; s.incLen = 1'b1;
          s.wrHi = cfgQ.bigEnd ? (cfgQ.wr == 2'd2 && wrGot == 2'd0) : (wrGot == 2'd1);
          nWr = wrGot + 2'd1;
          if (rdGot == cfgQ.rd && nWr == cfgQ.wr) begin
            if (cfgQ.rpt) nState = S_RPT;
            else begin s.pubNow = 1'b1; nState = S_IDLE; end
          end
        end else begin
          s.pubOld = 1'b1; nState = S_IDLE; actIdle = 1'b1;
        end
      end
      S_RPT: if (evValid) begin
        if (isRd && cfgQ.rd != 2'd0) begin
          s.capRd = 1'b1; s.incLen = 1'b1; nRd = 2'd1; nWr = 2'd0;
          nState = (cfgQ.rd == 2'd1 && cfgQ.wr == 2'd0) ? S_RPT : S_OPER;
        end else begin
          s.pubOld = 1'b1; nState = S_IDLE; actIdle = 1'b1;
        end
      end
      S_FIN: begin
        s.pubOld = 1'b1; nState = S_IDLE; actIdle = evValid;
      end
      default: nState = S_IDLE;
    endcase

    // Event handled as the start of a new instruction
    if (actIdle && isFetch) begin
      s.startIns = 1'b1; opcPfx = '0;
      if (pfxByte) begin
        s.loadPfx = 1'b1; nState = S_PFX;
      end else begin
        doOpc = 1'b1;
      end
    end

    if (doOpc) begin
      s.capOpc = 1'b1;
      if (!lkValid) begin
        errNext = 1'b1; codeNext = ERR_INVALID; nState = S_IDLE;
      end else begin
        nCfg = lkCfg; adv = 1'b1; advFrom = S_POPC;
      end
    end

    advCfg = doOpc ? lkCfg : cfgQ;
    advTo  = nextAfter(advCfg, advFrom);
    if (adv) begin
      if (advTo == S_IDLE) begin
        if (s.pubOld) nState = S_FIN;
        else begin s.pubNow = 1'b1; nState = S_IDLE; end
      end else begin
        nState = advTo;
        if (advTo == S_OPER) begin nRd = 2'd0; nWr = 2'd0; end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; cfgQ <= '0; rdGot <= '0; wrGot <= '0;
      errValid <= 1'b0; errCode <= '0;
    end else begin
      state <= nState; cfgQ <= nCfg; rdGot <= nRd; wrGot <= nWr;
      errValid <= errNext; errCode <= codeNext;
    end
  end

  assign stb      = s;
  assign lkPrefix = opcPfx;
  assign lkOpcode = evData;

  // R1: idle stays idle on any non-fetch event
  a_r1_idle_ignores: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && evValid && evType != EV_FETCH) |=> state == S_IDLE);

  // R9 / R10: an error pulse always carries a defined code
  a_r9_err_code: assert property (@(posedge clk) disable iff (!rstN)
    errValid |-> (errCode != 3'd0 && errCode <= ERR_INVALID));

  // R6: the repeat loop is entered only for repeating instructions
  a_r6_rpt_cfg: assert property (@(posedge clk) disable iff (!rstN)
    state == S_RPT |-> cfgQ.rpt);

  // R10: after an invalid opcode the sequencer is back in idle
  a_r10_invalid_idle: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && errCode == ERR_INVALID) |-> (state == S_IDLE || state == S_PFX || state == S_FIN));

endmodule

// File: rtl/z80_insn_seq.sv
module z80_insn_seq
  import z80seq_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evValid,
  input  logic [2:0]       evType,
  input  logic [7:0]       evData,
  output logic [15:0]      lkPrefix,
  output logic [7:0]       lkOpcode,
  input  logic             lkValid,
  input  logic             lkDisp,
  input  logic [1:0]       lkImm,
  input  logic [1:0]       lkRead,
  input  logic [1:0]       lkWrite,
  input  logic             lkWrBigEnd,
  input  logic             lkRepeat,
  output logic             insDone,
  output logic [15:0]      insPrefix,
  output logic [7:0]       insOpcode,
  output logic [15:0]      insDisp,
  output logic [15:0]      insImm,
  output logic [15:0]      insRead,
  output logic [15:0]      insWrite,
  output logic [LEN_W-1:0] insLen,
  output logic             errValid,
  output logic [2:0]       errCode
);

  strobe_t     stb;
  opCfg_t      lkCfg;
  logic [15:0] curPrefix;

  assign lkCfg = '{dis: lkDisp, imm: lkImm, rd: lkRead, wr: lkWrite,
                   bigEnd: lkWrBigEnd, rpt: lkRepeat};

  z80seq_control u_ctl (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evType(evType), .evData(evData),
    .lkValid(lkValid), .lkCfg(lkCfg), .curPrefix(curPrefix),
    .lkPrefix(lkPrefix), .lkOpcode(lkOpcode), .stb(stb),
    .errValid(errValid), .errCode(errCode)
  );

  z80seq_datapath #(.LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .evData(evData), .curPrefix(curPrefix),
    .insDone(insDone), .insPrefix(insPrefix), .insOpcode(insOpcode),
    .insDisp(insDisp), .insImm(insImm), .insRead(insRead),
    .insWrite(insWrite), .insLen(insLen)
  );

endmodule

// File: tb/tb_z80_insn_seq.sv
`timescale 1ns/1ps
module tb_z80_insn_seq;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evValid = 1'b0;
  logic [2:0] evType = 3'd0;
  logic [7:0] evData = 8'h00;
  logic [15:0] lkPrefix;
  logic [7:0] lkOpcode;
  logic lkValid, lkDisp, lkWrBigEnd, lkRepeat;
  logic [1:0] lkImm, lkRead, lkWrite;
  logic insDone, errValid;
  logic [15:0] insPrefix, insDisp, insImm, insRead, insWrite;
  logic [7:0] insOpcode;
  logic [3:0] insLen;
  logic [2:0] errCode;

  always #2.5 clk = ~clk;

  z80_insn_seq dut (.*);

  // Bench opcode table
  always_comb begin
    lkValid = 1'b1; lkDisp = 1'b0; lkImm = 2'd0; lkRead = 2'd0;
    lkWrite = 2'd0; lkWrBigEnd = 1'b0; lkRepeat = 1'b0;
    if (lkPrefix == 16'hDDCB || lkPrefix == 16'hFDCB) begin
      lkRead = 2'd1; lkWrite = 2'd1;
    end else if (lkOpcode == 8'hFF || (lkPrefix == 16'h00ED && lkOpcode == 8'h00)) begin
      lkValid = 1'b0;
    end else if (lkPrefix == 16'h00ED && lkOpcode == 8'hB0) begin
      lkRead = 2'd1; lkWrite = 2'd1; lkRepeat = 1'b1;
    end else begin
      case (lkOpcode)
        8'h01: lkImm = 2'd2;
        8'h06: lkImm = 2'd1;
        8'h0A: lkRead = 2'd1;
        8'h02: lkWrite = 2'd1;
        8'h22: begin lkImm = 2'd2; lkWrite = 2'd2; end
        8'h2A: begin lkImm = 2'd2; lkRead = 2'd2; end
        8'hE3: begin lkRead = 2'd2; lkWrite = 2'd2; lkWrBigEnd = 1'b1; end
        8'h36: begin lkImm = 2'd1; lkDisp = (lkPrefix == 16'h00DD || lkPrefix == 16'h00FD); end
        default: ;
      endcase
    end
  end

  typedef struct packed {
    logic [0:6][11:0] ev;   // {0,type[2:0],data[7:0]}, type 0 = unused
    logic [7:0]  req;
    logic [1:0]  dones;
    logic [2:0]  err;
    logic [15:0] pfx;
    logic [7:0]  opc;
    logic [15:0] disp;
    logic [15:0] imm;
    logic [15:0] rd;
    logic [15:0] wr;
    logic [3:0]  len;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    // R7 bare opcode
    '{{12'h100,12'h000,12'h000,12'h000,12'h000,12'h000,12'h000}, 8'd7, 2'd1, 3'd0, 16'h0000, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 4'd1},
    // R4 two-byte immediate, low first
    '{{12'h101,12'h234,12'h212,12'h000,12'h000,12'h000,12'h000}, 8'd4, 2'd1, 3'd0, 16'h0000, 8'h01, 16'h0000, 16'h1234, 16'h0000, 16'h0000, 4'd3},
    // R4 one-byte immediate
    '{{12'h106,12'h27F,12'h000,12'h000,12'h000,12'h000,12'h000}, 8'd4, 2'd1, 3'd0, 16'h0000, 8'h06, 16'h0000, 16'h007F, 16'h0000, 16'h0000, 4'd2},
    // R5 one-byte read
    '{{12'h10A,12'h255,12'h000,12'h000,12'h000,12'h000,12'h000}, 8'd5, 2'd1, 3'd0, 16'h0000, 8'h0A, 16'h0000, 16'h0000, 16'h0055, 16'h0000, 4'd2},
    // R5 two-byte write, little-endian
    '{{12'h122,12'h200,12'h280,12'h311,12'h322,12'h000,12'h000}, 8'd5, 2'd1, 3'd0, 16'h0000, 8'h22, 16'h0000, 16'h8000, 16'h0000, 16'h2211, 4'd5},
    // R5 two-byte read then big-endian write
    '{{12'h1E3,12'h234,12'h212,12'h356,12'h378,12'h000,12'h000}, 8'd5, 2'd1, 3'd0, 16'h0000, 8'hE3, 16'h0000, 16'h0000, 16'h1234, 16'h5678, 4'd5},
    // R4 displacement after opcode, then immediate
    '{{12'h1DD,12'h136,12'h2FE,12'h299,12'h000,12'h000,12'h000}, 8'd4, 2'd1, 3'd0, 16'h00DD, 8'h36, 16'hFFFE, 16'h0099, 16'h0000, 16'h0000, 4'd4},
    // R3 indexed bit form, displacement before opcode
    '{{12'h1DD,12'h1CB,12'h2F0,12'h206,12'h240,12'h341,12'h000}, 8'd3, 2'd1, 3'd0, 16'hDDCB, 8'h06, 16'hFFF0, 16'h0000, 16'h0040, 16'h0041, 4'd6},
    // R2 prefix chain keeps the last prefix
    '{{12'h1DD,12'h1ED,12'h101,12'h2AA,12'h2BB,12'h000,12'h000}, 8'd2, 2'd1, 3'd0, 16'h00ED, 8'h01, 16'h0000, 16'hBBAA, 16'h0000, 16'h0000, 4'd5},
    // R6 repeating block op, ended by a fetch
    '{{12'h1ED,12'h1B0,12'h211,12'h311,12'h222,12'h322,12'h100}, 8'd6, 2'd2, 3'd0, 16'h00ED, 8'hB0, 16'h0000, 16'h0000, 16'h0022, 16'h0022, 4'd6},
    // R9 prefix then non-fetch: code 1
    '{{12'h1DD,12'h200,12'h000,12'h000,12'h000,12'h000,12'h000}, 8'd9, 2'd0, 3'd1, 16'h0000, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 4'd0},
    // R9 missing displacement: code 2, fetch restarts
    '{{12'h1DD,12'h1CB,12'h100,12'h000,12'h000,12'h000,12'h000}, 8'd9, 2'd1, 3'd2, 16'h0000, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 4'd1},
    // R9 missing opcode: code 3
    '{{12'h1FD,12'h1CB,12'h210,12'h300,12'h000,12'h000,12'h000}, 8'd9, 2'd0, 3'd3, 16'h0000, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 4'd0},
    // R10 invalid unprefixed opcode
    '{{12'h1FF,12'h000,12'h000,12'h000,12'h000,12'h000,12'h000}, 8'd10, 2'd0, 3'd4, 16'h0000, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 4'd0},
    // R10 invalid under a prefix
    '{{12'h1ED,12'h100,12'h000,12'h000,12'h000,12'h000,12'h000}, 8'd10, 2'd0, 3'd4, 16'h0000, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 4'd0},
    // R1 idle ignores non-fetch events
    '{{12'h212,12'h334,12'h600,12'h4AA,12'h100,12'h000,12'h000}, 8'd1, 2'd1, 3'd0, 16'h0000, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 4'd1},
    // R7 operand cut short by a fetch, then deferred publish
    '{{12'h10A,12'h100,12'h000,12'h000,12'h000,12'h000,12'h000}, 8'd7, 2'd2, 3'd0, 16'h0000, 8'h0A, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 4'd1}
  };

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // Output monitor (samples away from the active edge)
  int doneCnt;
  logic [2:0] gotErr;
  logic [15:0] gPfx, gDisp, gImm, gRd, gWr;
  logic [7:0] gOpc;
  logic [3:0] gLen;

  always @(negedge clk) begin
    if (insDone) begin
      if (doneCnt == 0) begin
        gPfx = insPrefix; gOpc = insOpcode; gDisp = insDisp; gImm = insImm;
        gRd = insRead; gWr = insWrite; gLen = insLen;
      end
      doneCnt = doneCnt + 1;
    end
    if (errValid && gotErr == 3'd0) gotErr = errCode;
  end

  task automatic clearMon();
    doneCnt = 0; gotErr = 3'd0;
    gPfx = '0; gOpc = '0; gDisp = '0; gImm = '0; gRd = '0; gWr = '0; gLen = '0;
  endtask

  task automatic sendEv(input logic [2:0] t, input logic [7:0] d);
    @(negedge clk);
    evValid = 1'b1; evType = t; evData = d;
    @(negedge clk);
    evValid = 1'b0; evType = 3'd0; evData = 8'h00;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    clearMon();
    repeat (3) @(negedge clk);
    // R11: reset state at the ports
    checks++;
    if (insDone !== 1'b0 || errValid !== 1'b0 || insLen !== 4'd0 || insPrefix !== 16'h0) begin
      fails++;
      $display("FAIL R11 reset: done=%b err=%b len=%0d pfx=%h expected 0 0 0 0000",
               insDone, errValid, insLen, insPrefix);
    end
    rstN = 1'b1;
    settle();

    for (int v = 0; v < NV; v++) begin
      clearMon();
      for (int e = 0; e < 7; e++)
        if (VECS[v].ev[e][10:8] != 3'd0) sendEv(VECS[v].ev[e][10:8], VECS[v].ev[e][7:0]);
      settle();
      checks++;
      if (doneCnt != int'(VECS[v].dones) || gotErr !== VECS[v].err ||
          (VECS[v].dones != 2'd0 &&
           (gPfx !== VECS[v].pfx || gOpc !== VECS[v].opc || gDisp !== VECS[v].disp ||
            gImm !== VECS[v].imm || gRd !== VECS[v].rd || gWr !== VECS[v].wr ||
            gLen !== VECS[v].len))) begin
        fails++;
        $display("FAIL R%0d vec %0d: dones=%0d err=%0d pfx=%h opc=%h disp=%h imm=%h rd=%h wr=%h len=%0d expected dones=%0d err=%0d pfx=%h opc=%h disp=%h imm=%h rd=%h wr=%h len=%0d",
                 VECS[v].req, v, doneCnt, gotErr, gPfx, gOpc, gDisp, gImm, gRd, gWr, gLen,
                 VECS[v].dones, VECS[v].err, VECS[v].pfx, VECS[v].opc, VECS[v].disp,
                 VECS[v].imm, VECS[v].rd, VECS[v].wr, VECS[v].len);
      end
    end

    // R2: lookup key presented in the cycle of the opcode fetch
    clearMon();
    sendEv(3'd1, 8'hDD);
    @(negedge clk);
    evValid = 1'b1; evType = 3'd1; evData = 8'h36;
    #1;
    checks++;
    if (lkPrefix !== 16'h00DD || lkOpcode !== 8'h36) begin
      fails++;
      $display("FAIL R2 lookup key: pfx=%h opc=%h expected 00dd 36", lkPrefix, lkOpcode);
    end
    @(negedge clk);
    evValid = 1'b0; evType = 3'd0; evData = 8'h00;
    sendEv(3'd2, 8'h80);
    sendEv(3'd2, 8'h01);
    settle();
    // R4: negative post-opcode displacement sign-extended
    checks++;
    if (doneCnt != 1 || gDisp !== 16'hFF80 || gImm !== 16'h0001 || gLen !== 4'd4) begin
      fails++;
      $display("FAIL R4 disp: dones=%0d disp=%h imm=%h len=%0d expected 1 ff80 0001 4",
               doneCnt, gDisp, gImm, gLen);
    end

    // R11: reset discards a partly assembled instruction
    clearMon();
    sendEv(3'd1, 8'hFD);
    sendEv(3'd1, 8'hCB);
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    sendEv(3'd1, 8'h00);
    settle();
    checks++;
    if (doneCnt != 1 || gPfx !== 16'h0000 || gLen !== 4'd1 || gotErr !== 3'd0) begin
      fails++;
      $display("FAIL R11 mid reset: dones=%0d pfx=%h len=%0d err=%0d expected 1 0000 1 0",
               doneCnt, gPfx, gLen, gotErr);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule